// File: doc/BRIEF.md
# Security-Tagged Cache Way Hit Logic

This block performs the tag-compare stage of a set-associative level-one lookup that is indexed with the virtual address and tagged with the physical address. In the lookup cycle the caller presents the virtual address, the translated physical address and the translation's security attribute together. The low virtual address bits pick one set. Every way of that set then compares its stored physical tag and its stored non-secure bit against the incoming values. A base compare for a tightly coupled memory (TCM) runs alongside the way compares.

The results are registered and appear one cycle later. They are a one-hot per-way hit vector, a TCM hit, a miss flag, a multi-hit error flag and a read-data select. For writes the block also names the target, TCM or way, for the write buffer. The tag array is held in plain registers. A simple fill port loads or invalidates single entries so the array can be exercised. Refill policy, replacement and the translation buffer live elsewhere.

Top module: `cht_hit_top`

## Requirements
- R1: The set is chosen only by virtual address bits [10:5] (64 sets of 32-byte lines). The compared tag is physical address bits [31:11]. The same physical address looked up with a different set index does not hit an entry filled at another set.
- R2: A way hits only when its valid bit is 1, its stored tag equals physical address bits [31:11] and its stored non-secure bit equals the lookup's non-secure attribute. A tag match with a differing non-secure bit is a miss. Bit i of `way_hit_o` stands for way i.
- R3: `tcm_hit_o` is 1 exactly when `tcm_en_i` is 1 and physical address bits [31:14] equal `tcm_base_i` bits [31:14]. This holds whatever the ways hold.
- R4: All results for a lookup presented in one cycle appear in the following cycle, with `res_vld_o` = 1. In a cycle after no lookup, `res_vld_o` and every other output are 0.
- R5: `miss_o` is 1 for a completed lookup when no way and no TCM hit.
- R6: `multi_hit_o` is 1 when two or more ways hit. `rd_sel_o` then names the lowest-numbered hitting way.
- R7: The read select is as follows. `rd_sel_tcm_o` = 1 on a TCM hit, and the TCM takes priority over the ways. `rd_sel_o` is the binary index of the lowest hitting way, or 0 when no way hits.
- R8: For a lookup with `lk_write_i` = 1 that hits, `wb_req_o` = 1. On a TCM hit, `wb_tcm_o` = 1 and `wb_way_o` = 0. Otherwise `wb_tcm_o` = 0 and `wb_way_o` is the selected way. Reads and write misses leave all three at 0.
- R9: A fill with `fill_en_i` = 1 writes valid, non-secure bit and tag into the addressed way and set at the clock edge. Lookups in later cycles see it. A fill with `fill_vld_i` = 0 invalidates the entry. Reset clears every valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_req_i | input | 1 | Lookup presented this cycle |
| lk_write_i | input | 1 | Lookup is a write |
| lk_vaddr_i | input | 32 | Virtual address (set index source) |
| lk_paddr_i | input | 32 | Translated physical address |
| lk_ns_i | input | 1 | Non-secure attribute of the translation |
| tcm_en_i | input | 1 | TCM region enabled |
| tcm_base_i | input | 32 | TCM base address |
| fill_en_i | input | 1 | Write one tag entry |
| fill_way_i | input | 2 | Way to write |
| fill_set_i | input | 6 | Set to write |
| fill_tag_i | input | 21 | Tag to store |
| fill_ns_i | input | 1 | Non-secure bit to store |
| fill_vld_i | input | 1 | Valid bit to store |
| res_vld_o | output | 1 | Result valid |
| way_hit_o | output | 4 | One-hot way hit vector |
| tcm_hit_o | output | 1 | TCM hit |
| miss_o | output | 1 | Neither way nor TCM hit |
| multi_hit_o | output | 1 | More than one way hit |
| rd_sel_o | output | 2 | Selected way index for read data |
| rd_sel_tcm_o | output | 1 | Read data comes from TCM |
| wb_req_o | output | 1 | Write hit, target valid |
| wb_tcm_o | output | 1 | Write target is the TCM |
| wb_way_o | output | 2 | Write target way |

## Verification
Each lookup's results are due in the cycle after the cycle in which the lookup is held on the inputs. The bench drives a lookup at a falling edge and lets one rising edge capture it. It compares every output at the next falling edge, where it also withdraws the request. A fill takes effect at the rising edge that samples it. The bench therefore finishes each fill on its own cycle and only then issues lookups that depend on it. The bench's array model is updated at that same point. Idle cycles are sampled one edge after a lookup ends to confirm the outputs return to zero.

// File: rtl/cht_pkg.sv
package cht_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_WAY  = 2'd1,
      TGT_TCM  = 2'd2
   } tgt_e;

   function automatic int unsigned log2c(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/cht_tag_store.sv
module cht_tag_store #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned SETS  = 64,
   parameter int unsigned TAG_W = 21,
   localparam int unsigned IDX_W = cht_pkg::log2c(SETS),
   localparam int unsigned WAY_W = (WAYS > 1) ? cht_pkg::log2c(WAYS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [WAYS-1:0]             rd_vld,
   output logic [WAYS-1:0]             rd_ns,
   output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
   input  logic                        wr_en,
   input  logic [WAY_W-1:0]            wr_way,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [TAG_W-1:0]            wr_tag,
   input  logic                        wr_ns,
   input  logic                        wr_vld
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]             vld_q;
      logic [SETS-1:0]             ns_q;
      logic [SETS-1:0][TAG_W-1:0]  tag_q;
      logic                        sel;

      assign sel = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
         end else if (sel) begin
            vld_q[wr_idx] <= wr_vld;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            ns_q[wr_idx]  <= wr_ns;
            tag_q[wr_idx] <= wr_tag;
         end
      end

      assign rd_vld[w] = vld_q[rd_idx];
      assign rd_ns[w]  = ns_q[rd_idx];
      assign rd_tag[w] = tag_q[rd_idx];
   end
endmodule

// File: rtl/cht_way_cmp.sv
module cht_way_cmp #(
   parameter int unsigned TAG_W = 21
) (
   input  logic             ent_vld,
   input  logic             ent_ns,
   input  logic [TAG_W-1:0] ent_tag,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             req_ns,
   output logic             hit
);
   logic tag_eq;
   logic sec_eq;

   assign tag_eq = (ent_tag == req_tag);
   assign sec_eq = (ent_ns == req_ns);
   assign hit    = ent_vld && tag_eq && sec_eq;
endmodule

// File: rtl/cht_tcm_cmp.sv
module cht_tcm_cmp #(
   parameter int unsigned PA_W   = 32,
   parameter int unsigned TCM_AW = 14
) (
   input  logic            en,
   input  logic [PA_W-1:0] base,
   input  logic [PA_W-1:0] paddr,
   output logic            hit
);
   localparam int unsigned HI_W = PA_W - TCM_AW;

   logic [HI_W-1:0] base_hi;
   logic [HI_W-1:0] addr_hi;

   assign base_hi = base[PA_W-1:TCM_AW];
   assign addr_hi = paddr[PA_W-1:TCM_AW];
   assign hit     = en && (base_hi == addr_hi);
endmodule

// File: rtl/cht_resolve.sv
module cht_resolve #(
   parameter int unsigned WAYS = 4,
   localparam int unsigned WAY_W = (WAYS > 1) ? cht_pkg::log2c(WAYS) : 1,
   localparam int unsigned CNT_W = cht_pkg::log2c(WAYS + 1)
) (
   input  logic [WAYS-1:0]  way_hit,
   input  logic             tcm_hit,
   input  logic             is_write,
   output logic             miss,
   output logic             multi,
   output logic [WAY_W-1:0] sel_way,
   output logic             sel_tcm,
   output logic             wb_req,
   output logic             wb_tcm,
   output logic [WAY_W-1:0] wb_way
);
   import cht_pkg::*;

   logic [CNT_W-1:0] n_hit;
   logic             any_way;
   tgt_e             tgt;

   always_comb begin
      n_hit   = '0;
      sel_way = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (way_hit[i]) begin
            n_hit   = n_hit + CNT_W'(1);
            sel_way = WAY_W'(i);
         end
      end
   end

   assign any_way = |way_hit;
   assign multi   = (n_hit > CNT_W'(1));

   always_comb begin
      if (tcm_hit)      tgt = TGT_TCM;
      else if (any_way) tgt = TGT_WAY;
      else              tgt = TGT_NONE;
   end

   assign miss    = (tgt == TGT_NONE);
   assign sel_tcm = (tgt == TGT_TCM);
   assign wb_req  = is_write && (tgt != TGT_NONE);
   assign wb_tcm  = is_write && (tgt == TGT_TCM);
   assign wb_way  = (is_write && tgt == TGT_WAY) ? sel_way : '0;
endmodule

// File: rtl/cht_hit_top.sv
module cht_hit_top #(
   parameter int unsigned WAYS    = 4,
   parameter int unsigned SETS    = 64,
   parameter int unsigned LINE_B  = 32,
   parameter int unsigned PA_W    = 32,
   parameter int unsigned VA_W    = 32,
   parameter int unsigned TCM_AW  = 14,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned OFF_W  = cht_pkg::log2c(LINE_B),
   localparam int unsigned IDX_W  = cht_pkg::log2c(SETS),
   localparam int unsigned TAG_W  = PA_W - IDX_W - OFF_W,
   localparam int unsigned WAY_W  = (WAYS > 1) ? cht_pkg::log2c(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req_i,
   input  logic              lk_write_i,
   input  logic [VA_W-1:0]   lk_vaddr_i,
   input  logic [PA_W-1:0]   lk_paddr_i,
   input  logic              lk_ns_i,
   input  logic              tcm_en_i,
   input  logic [PA_W-1:0]   tcm_base_i,
   input  logic              fill_en_i,
   input  logic [WAY_W-1:0]  fill_way_i,
   input  logic [IDX_W-1:0]  fill_set_i,
   input  logic [TAG_W-1:0]  fill_tag_i,
   input  logic              fill_ns_i,
   input  logic              fill_vld_i,
   output logic              res_vld_o,
   output logic [WAYS-1:0]   way_hit_o,
   output logic              tcm_hit_o,
   output logic              miss_o,
   output logic              multi_hit_o,
   output logic [WAY_W-1:0]  rd_sel_o,
   output logic              rd_sel_tcm_o,
   output logic              wb_req_o,
   output logic              wb_tcm_o,
   output logic [WAY_W-1:0]  wb_way_o
);
   if ((1 << IDX_W) != SETS) begin : g_chk_sets
      $error("SETS must be a power of two");
   end
   if ((1 << OFF_W) != LINE_B) begin : g_chk_line
      $error("LINE_B must be a power of two");
   end
   if (PA_W <= IDX_W + OFF_W) begin : g_chk_tag
      $error("physical address too narrow for index and offset");
   end
   if (VA_W < IDX_W + OFF_W) begin : g_chk_va
      $error("virtual address too narrow for index");
   end
   if (TCM_AW >= PA_W) begin : g_chk_tcm
      $error("TCM_AW must be below PA_W");
   end
   if (WAYS < 1) begin : g_chk_ways
      $error("WAYS must be at least one");
   end

   logic [IDX_W-1:0]             idx;
   logic [TAG_W-1:0]             req_tag;
   logic [WAYS-1:0]              e_vld;
   logic [WAYS-1:0]              e_ns;
   logic [WAYS-1:0][TAG_W-1:0]   e_tag;
   logic [WAYS-1:0]              hit_raw;
   logic                         tcm_raw;
   logic                         c_miss, c_multi, c_sel_tcm, c_wb_req, c_wb_tcm;
   logic [WAY_W-1:0]             c_sel, c_wb_way;

   assign idx     = lk_vaddr_i[OFF_W+IDX_W-1:OFF_W];
   assign req_tag = lk_paddr_i[PA_W-1:OFF_W+IDX_W];

   cht_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (idx),
      .rd_vld (e_vld),
      .rd_ns  (e_ns),
      .rd_tag (e_tag),
      .wr_en  (fill_en_i),
      .wr_way (fill_way_i),
      .wr_idx (fill_set_i),
      .wr_tag (fill_tag_i),
      .wr_ns  (fill_ns_i),
      .wr_vld (fill_vld_i)
   );

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      cht_way_cmp #(.TAG_W(TAG_W)) u_cmp (
         .ent_vld (e_vld[w]),
         .ent_ns  (e_ns[w]),
         .ent_tag (e_tag[w]),
         .req_tag (req_tag),
         .req_ns  (lk_ns_i),
         .hit     (hit_raw[w])
      );
   end

   cht_tcm_cmp #(.PA_W(PA_W), .TCM_AW(TCM_AW)) u_tcm (
      .en    (tcm_en_i),
      .base  (tcm_base_i),
      .paddr (lk_paddr_i),
      .hit   (tcm_raw)
   );

   cht_resolve #(.WAYS(WAYS)) u_res (
      .way_hit  (hit_raw),
      .tcm_hit  (tcm_raw),
      .is_write (lk_write_i),
      .miss     (c_miss),
      .multi    (c_multi),
      .sel_way  (c_sel),
      .sel_tcm  (c_sel_tcm),
      .wb_req   (c_wb_req),
      .wb_tcm   (c_wb_tcm),
      .wb_way   (c_wb_way)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_vld_o    <= 1'b0;
            way_hit_o    <= '0;
            tcm_hit_o    <= 1'b0;
            miss_o       <= 1'b0;
            multi_hit_o  <= 1'b0;
            rd_sel_o     <= '0;
            rd_sel_tcm_o <= 1'b0;
            wb_req_o     <= 1'b0;
            wb_tcm_o     <= 1'b0;
            wb_way_o     <= '0;
         end else begin
            res_vld_o    <= lk_req_i;
            way_hit_o    <= lk_req_i ? hit_raw : '0;
            tcm_hit_o    <= lk_req_i && tcm_raw;
            miss_o       <= lk_req_i && c_miss;
            multi_hit_o  <= lk_req_i && c_multi;
            rd_sel_o     <= lk_req_i ? c_sel : '0;
            rd_sel_tcm_o <= lk_req_i && c_sel_tcm;
            wb_req_o     <= lk_req_i && c_wb_req;
            wb_tcm_o     <= lk_req_i && c_wb_tcm;
            wb_way_o     <= lk_req_i ? c_wb_way : '0;
         end
      end
   end else begin : g_comb
      assign res_vld_o    = lk_req_i;
      assign way_hit_o    = lk_req_i ? hit_raw : '0;
      assign tcm_hit_o    = lk_req_i && tcm_raw;
      assign miss_o       = lk_req_i && c_miss;
      assign multi_hit_o  = lk_req_i && c_multi;
      assign rd_sel_o     = lk_req_i ? c_sel : '0;
      assign rd_sel_tcm_o = lk_req_i && c_sel_tcm;
      assign wb_req_o     = lk_req_i && c_wb_req;
      assign wb_tcm_o     = lk_req_i && c_wb_tcm;
      assign wb_way_o     = lk_req_i ? c_wb_way : '0;
   end
endmodule

// File: rtl/cht_hit_chk.sv
module cht_hit_chk #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_req_i,
   input logic             lk_write_i,
   input logic             tcm_en_i,
   input logic             res_vld_o,
   input logic [WAYS-1:0]  way_hit_o,
   input logic             tcm_hit_o,
   input logic             miss_o,
   input logic             multi_hit_o,
   input logic             rd_sel_tcm_o,
   input logic             wb_req_o,
   input logic             wb_tcm_o,
   input logic [WAY_W-1:0] wb_way_o
);
   assert_result_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req_i |=> res_vld_o);

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req_i |=> (!res_vld_o && way_hit_o == '0 && !tcm_hit_o && !miss_o && !wb_req_o));

   assert_tcm_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req_i && !tcm_en_i) |=> !tcm_hit_o);

   assert_single_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !multi_hit_o |-> $onehot0(way_hit_o));

   assert_multi_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      multi_hit_o |-> ($countones(way_hit_o) > 1));

   assert_miss_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> (way_hit_o == '0 && !tcm_hit_o && !rd_sel_tcm_o));

   assert_tcm_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tcm_hit_o |-> rd_sel_tcm_o);

   assert_read_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req_i && !lk_write_i) |=> !wb_req_o);

   assert_wb_tcm_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_tcm_o |-> (wb_req_o && wb_way_o == '0));
endmodule

bind cht_hit_top cht_hit_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_req_i     (lk_req_i),
   .lk_write_i   (lk_write_i),
   .tcm_en_i     (tcm_en_i),
   .res_vld_o    (res_vld_o),
   .way_hit_o    (way_hit_o),
   .tcm_hit_o    (tcm_hit_o),
   .miss_o       (miss_o),
   .multi_hit_o  (multi_hit_o),
   .rd_sel_tcm_o (rd_sel_tcm_o),
   .wb_req_o     (wb_req_o),
   .wb_tcm_o     (wb_tcm_o),
   .wb_way_o     (wb_way_o)
);

// File: tb/sim_cht_hit_top.sv
module sim_cht_hit_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req_i = 1'b0, lk_write_i = 1'b0, lk_ns_i = 1'b0;
   logic [31:0] lk_vaddr_i = '0, lk_paddr_i = '0;
   logic        tcm_en_i = 1'b0;
   logic [31:0] tcm_base_i = '0;
   logic        fill_en_i = 1'b0, fill_ns_i = 1'b0, fill_vld_i = 1'b0;
   logic [1:0]  fill_way_i = '0;
   logic [5:0]  fill_set_i = '0;
   logic [20:0] fill_tag_i = '0;
   logic        res_vld_o, tcm_hit_o, miss_o, multi_hit_o, rd_sel_tcm_o;
   logic        wb_req_o, wb_tcm_o;
   logic [3:0]  way_hit_o;
   logic [1:0]  rd_sel_o, wb_way_o;

   int n_chk = 0;
   int n_err = 0;

   logic        m_vld [4][64];
   logic        m_ns  [4][64];
   logic [20:0] m_tag [4][64];

   always #2.5 clk = ~clk;

   cht_hit_top u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_hits(input logic [31:0] va, input logic [31:0] pa, input logic ns);
      logic [3:0] h;
      for (int w = 0; w < 4; w++)
         h[w] = m_vld[w][va[10:5]] && (m_tag[w][va[10:5]] == pa[31:11]) && (m_ns[w][va[10:5]] == ns);
      return h;
   endfunction

   function automatic logic [1:0] low_idx(input logic [3:0] h);
      logic [1:0] r;
      r = 2'd0;
      for (int w = 3; w >= 0; w--) if (h[w]) r = 2'(w);
      return r;
   endfunction

   task automatic fill(input int w, input int s, input logic [20:0] t, input logic ns, input logic v);
      @(negedge clk);
      fill_en_i = 1'b1; fill_way_i = 2'(w); fill_set_i = 6'(s);
      fill_tag_i = t; fill_ns_i = ns; fill_vld_i = v;
      @(posedge clk);
      m_vld[w][s] = v; m_ns[w][s] = ns; m_tag[w][s] = t;
      @(negedge clk);
      fill_en_i = 1'b0;
   endtask

   task automatic lookup(input logic [31:0] va, input logic [31:0] pa, input logic ns, input logic wr);
      logic [3:0] h;
      logic       th, any;
      logic [1:0] sel;
      h   = exp_hits(va, pa, ns);
      th  = tcm_en_i && (pa[31:14] == tcm_base_i[31:14]);
      any = (h != 0) || th;
      sel = low_idx(h);
      @(negedge clk);
      lk_req_i = 1'b1; lk_vaddr_i = va; lk_paddr_i = pa; lk_ns_i = ns; lk_write_i = wr;
      @(negedge clk);
      lk_req_i = 1'b0;
      chk("R4 res_vld", 32'(res_vld_o), 32'd1);
      chk("R2 way_hit", 32'(way_hit_o), 32'(h));
      chk("R3 tcm_hit", 32'(tcm_hit_o), 32'(th));
      chk("R5 miss", 32'(miss_o), 32'(!any));
      chk("R6 multi_hit", 32'(multi_hit_o), 32'($countones(h) > 1));
      chk("R7 rd_sel", 32'(rd_sel_o), 32'(sel));
      chk("R7 rd_sel_tcm", 32'(rd_sel_tcm_o), 32'(th));
      chk("R8 wb_req", 32'(wb_req_o), 32'(wr && any));
      chk("R8 wb_tcm", 32'(wb_tcm_o), 32'(wr && th));
      chk("R8 wb_way", 32'(wb_way_o), 32'((wr && !th && h != 0) ? sel : 2'd0));
   endtask

   function automatic logic [31:0] mk_pa(input logic [20:0] t, input logic [10:0] lo);
      return {t, lo};
   endfunction

   initial begin
      void'($urandom(32'd1776));
      for (int w = 0; w < 4; w++)
         for (int s = 0; s < 64; s++) begin
            m_vld[w][s] = 1'b0; m_ns[w][s] = 1'b0; m_tag[w][s] = '0;
         end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R4 reset state
      chk("R4 reset res_vld", 32'(res_vld_o), 32'd0);
      chk("R4 reset way_hit", 32'(way_hit_o), 32'd0);
      // R9 reset clears valids: any lookup misses
      lookup(32'h0000_00A0, mk_pa(21'h0, 11'h0A0), 1'b0, 1'b0);

      // R2 basic hit and security mismatch
      fill(0, 5, 21'h12345, 1'b0, 1'b1);
      lookup(32'h0000_00A4, mk_pa(21'h12345, 11'h0A4), 1'b0, 1'b0);
      lookup(32'h0000_00A4, mk_pa(21'h12345, 11'h0A4), 1'b1, 1'b0);
      // R1 other set index, same physical address
      lookup(32'h0000_00C4, mk_pa(21'h12345, 11'h0A4), 1'b0, 1'b0);
      // R6 multi-hit with lowest index select
      fill(3, 9, 21'h0BEEF, 1'b1, 1'b1);
      fill(1, 9, 21'h0BEEF, 1'b1, 1'b1);
      lookup(32'h0000_0120, mk_pa(21'h0BEEF, 11'h120), 1'b1, 1'b1);
      // R9 invalidate
      fill(0, 5, 21'h12345, 1'b0, 1'b0);
      lookup(32'h0000_00A4, mk_pa(21'h12345, 11'h0A4), 1'b0, 1'b1);
      // R3 / R7 / R8 TCM priority over a way hit
      fill(2, 3, 21'h00040, 1'b0, 1'b1);
      tcm_en_i = 1'b1; tcm_base_i = 32'h0002_0000;
      lookup(32'h0000_0060, mk_pa(21'h00040, 11'h060), 1'b0, 1'b1);
      lookup(32'h0000_0060, mk_pa(21'h00040, 11'h060), 1'b0, 1'b0);
      // R3 TCM disabled: way hit only, write to way
      tcm_en_i = 1'b0;
      lookup(32'h0000_0060, mk_pa(21'h00040, 11'h060), 1'b0, 1'b1);
      // R4 idle after lookup
      @(negedge clk);
      chk("R4 idle res_vld", 32'(res_vld_o), 32'd0);
      chk("R4 idle miss", 32'(miss_o), 32'd0);

      // random mix
      for (int k = 0; k < 600; k++) begin
         logic [20:0] t;
         logic [5:0]  s;
         t = 21'($urandom_range(0, 7)) | 21'h1F000;
         s = 6'($urandom_range(0, 7));
         if ($urandom_range(0, 2) == 0)
            fill($urandom_range(0, 3), s, t, 1'($urandom_range(0, 1)), ($urandom_range(0, 4) != 0));
         else begin
            tcm_en_i   = 1'($urandom_range(0, 1));
            tcm_base_i = {t[20:3], 14'($urandom)};
            lookup({21'($urandom), s, 5'($urandom)}, {t, s, 5'($urandom)},
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule